// File: doc/BRIEF.md
# Precision-Time Event Message Timestamper

This block sits beside one switch port and watches that port's receive byte stream and its transmit byte stream for precision-time-protocol event messages. Each direction has a start-of-frame strobe and a byte stream. The free-running 64-bit time is sampled on every start of frame. The block then parses the fixed-offset header fields: the message type, the 48-bit source identity and the 16-bit sequence number. When the last of these fields arrives and the type matches the one wanted for that direction, the block writes the timestamp, source identity and sequence number into that direction's record in a single cycle. In the same cycle it raises a sticky flag for the host.

Which message type a direction records depends on the node's role. A master records Delay_Req messages it receives and Sync messages it sends. A slave records Sync messages it receives and Delay_Req messages it sends. The byte streams are valid-qualified with no ready signal, because the block never applies back-pressure. A byte is taken on every clock edge where its valid is high, and the sender may leave idle cycles anywhere in a frame. The record ports and flags are plain status outputs that stay constant between captures.

Top module: `ptp_event_timestamper`

## Requirements
- R1: After reset every record output (timestamp, source identity, sequence number) of both directions is zero and both flags are low.
- R2: With `mode_master`=1 the receive direction records only frames whose type nibble is 1 (Delay_Req). Frames with type 0 (Sync) leave its record and flag unchanged.
- R3: With `mode_master`=0 the receive direction records only frames whose type nibble is 0 (Sync). Type-1 frames leave its record and flag unchanged.
- R4: The transmit direction records type 0 when `mode_master`=1 and type 1 when `mode_master`=0. Other types leave it unchanged.
- R5: A recorded timestamp equals the value of `time_now` at the clock edge where that frame's start-of-frame strobe was high.
- R6: Byte offsets count from 0, where offset 0 is the byte accepted with the start-of-frame strobe. The type is the low nibble of offset 0, and the high nibble is ignored. The source identity is offsets 2..7, most significant byte first. The sequence number is offsets 8..9, most significant byte first.
- R7: A flag rises with its capture and stays high until a one-cycle clear pulse on its direction. If a capture and a clear fall on the same edge, the flag ends high.
- R8: A later matching frame overwrites the whole record of its direction, and the flag stays high.
- R9: Cycles with valid low are ignored, even inside a frame. Bytes that arrive after the field bytes of a frame and before the next start of frame change nothing. A frame that stops before offset 9 changes nothing.
- R10: The two directions are independent. Traffic, clears and captures on one never change the other's record or flag.
- R11: The record and flag change on the clock edge that accepts offset 9, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_master | input | 1 | 1 = node acts as master, 0 = slave |
| time_now | input | 64 | Shared running time |
| rx_sof | input | 1 | Receive start of frame (with or before byte 0) |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_flag_clr | input | 1 | Host clears receive flag |
| tx_sof | input | 1 | Transmit start of frame |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_flag_clr | input | 1 | Host clears transmit flag |
| rx_ts | output | 64 | Receive recorded timestamp |
| rx_src_id | output | 48 | Receive recorded source identity |
| rx_seq | output | 16 | Receive recorded sequence number |
| rx_flag | output | 1 | Receive capture flag |
| tx_ts | output | 64 | Transmit recorded timestamp |
| tx_src_id | output | 48 | Transmit recorded source identity |
| tx_seq | output | 16 | Transmit recorded sequence number |
| tx_flag | output | 1 | Transmit capture flag |

## Verification
The assertions assume that `mode_master` does not change while a frame is being parsed. They also assume that a clear pulse lasts a single cycle. The properties themselves only rely on one fact: a record cannot change in a cycle where its direction's valid is low. The stimulus changes the role only between frames, and it drives the strobes, bytes and clears on the falling edge so that each is sampled at exactly one rising edge. Some frames include idle cycles, and some are cut short or followed by trailing bytes, so the ignored-byte rules are exercised while the inputs stay within those assumptions.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;

  localparam logic [3:0] MSG_SYNC    = 4'd0;
  localparam logic [3:0] MSG_DLY_REQ = 4'd1;

  localparam int TIME_W = 64;
  localparam int SRC_W  = 48;
  localparam int SEQ_W  = 16;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [3:0] wanted_type(input logic is_tx, input logic master);
    // master: rx Delay_Req, tx Sync; slave: rx Sync, tx Delay_Req
    return (is_tx ^ master) ? MSG_DLY_REQ : MSG_SYNC;
  endfunction

endpackage

// File: rtl/ptp_ts_field_asm.sv
module ptp_ts_field_asm
  import ptp_ts_pkg::*;
#(
  parameter int TYPE_OFS = 0,
  parameter int SRC_OFS  = 2,
  parameter int SEQ_OFS  = 8,
  parameter int LAST_OFS = 9,
  parameter int CW       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             valid,
  input  logic [7:0]       data,
  output logic             done,
  output logic [3:0]       type_nxt,
  output logic [SRC_W-1:0] src_nxt,
  output logic [SEQ_W-1:0] seq_nxt
);

  localparam int SRC_BYTES = SRC_W / 8;
  localparam int SEQ_BYTES = SEQ_W / 8;
  localparam logic [CW-1:0] TYPE_IDX = CW'(TYPE_OFS);
  localparam logic [CW-1:0] SRC_LO   = CW'(SRC_OFS);
  localparam logic [CW-1:0] SRC_HI   = CW'(SRC_OFS + SRC_BYTES - 1);
  localparam logic [CW-1:0] SEQ_LO   = CW'(SEQ_OFS);
  localparam logic [CW-1:0] SEQ_HI   = CW'(SEQ_OFS + SEQ_BYTES - 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(LAST_OFS);

  logic [CW-1:0]    cnt_q;
  logic             act_q;
  logic [3:0]       type_q;
  logic [SRC_W-1:0] src_q;
  logic [SEQ_W-1:0] seq_q;

  logic [CW-1:0] idx;
  logic          take;
  logic          in_src, in_seq;

  always_comb begin
    idx    = sof ? '0 : cnt_q;
    take   = valid && (sof || act_q);
    in_src = (idx >= SRC_LO) && (idx <= SRC_HI);
    in_seq = (idx >= SEQ_LO) && (idx <= SEQ_HI);
    done   = take && (idx == LAST_IDX);

    type_nxt = type_q;
    if (take && idx == TYPE_IDX) type_nxt = data[3:0];

    src_nxt = src_q;
    if (take && in_src) src_nxt = {src_q[SRC_W-9:0], data};

    seq_nxt = seq_q;
    if (take && in_seq) seq_nxt = {seq_q[SEQ_W-9:0], data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      type_q <= '0;
      src_q  <= '0;
      seq_q  <= '0;
    end else begin
      type_q <= type_nxt;
      src_q  <= src_nxt;
      seq_q  <= seq_nxt;
      if (sof) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end
      if (take) begin
        cnt_q <= idx + 1'b1;
        if (idx == LAST_IDX) act_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture
  import ptp_ts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic [TIME_W-1:0] time_now,
  input  logic              done,
  input  logic [3:0]        want_type,
  input  logic [3:0]        type_nxt,
  input  logic [SRC_W-1:0]  src_nxt,
  input  logic [SEQ_W-1:0]  seq_nxt,
  input  logic              clr,
  output logic [TIME_W-1:0] ts,
  output logic [SRC_W-1:0]  src_id,
  output logic [SEQ_W-1:0]  seq,
  output logic              flag
);

  logic [TIME_W-1:0] ts_pend_q;
  logic              hit;

  assign hit = done && (type_nxt == want_type);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_pend_q <= '0;
      ts        <= '0;
      src_id    <= '0;
      seq       <= '0;
      flag      <= 1'b0;
    end else begin
      if (sof) ts_pend_q <= time_now;
      if (hit) begin
        ts     <= sof ? time_now : ts_pend_q;
        src_id <= src_nxt;
        seq    <= seq_nxt;
      end
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/ptp_event_timestamper.sv
module ptp_event_timestamper
  import ptp_ts_pkg::*;
#(
  parameter int TYPE_OFS = 0,
  parameter int SRC_OFS  = 2,
  parameter int SEQ_OFS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_master,
  input  logic [TIME_W-1:0] time_now,
  input  logic              rx_sof,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_flag_clr,
  input  logic              tx_sof,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  input  logic              tx_flag_clr,
  output logic [TIME_W-1:0] rx_ts,
  output logic [SRC_W-1:0]  rx_src_id,
  output logic [SEQ_W-1:0]  rx_seq,
  output logic              rx_flag,
  output logic [TIME_W-1:0] tx_ts,
  output logic [SRC_W-1:0]  tx_src_id,
  output logic [SEQ_W-1:0]  tx_seq,
  output logic              tx_flag
);

  localparam int LAST_OFS = max3(TYPE_OFS, SRC_OFS + SRC_W/8 - 1, SEQ_OFS + SEQ_W/8 - 1);
  localparam int CW       = $clog2(LAST_OFS + 2);
  localparam int NDIR     = 2;

  logic              sof_a   [NDIR];
  logic              val_a   [NDIR];
  logic [7:0]        dat_a   [NDIR];
  logic              clr_a   [NDIR];
  logic [TIME_W-1:0] ts_a    [NDIR];
  logic [SRC_W-1:0]  src_a   [NDIR];
  logic [SEQ_W-1:0]  seq_a   [NDIR];
  logic              flag_a  [NDIR];

  assign sof_a[0] = rx_sof;   assign sof_a[1] = tx_sof;
  assign val_a[0] = rx_valid; assign val_a[1] = tx_valid;
  assign dat_a[0] = rx_data;  assign dat_a[1] = tx_data;
  assign clr_a[0] = rx_flag_clr; assign clr_a[1] = tx_flag_clr;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic             done;
    logic [3:0]       type_nxt;
    logic [SRC_W-1:0] src_nxt;
    logic [SEQ_W-1:0] seq_nxt;
    logic [3:0]       want;

    assign want = wanted_type(1'(d), mode_master);

    ptp_ts_field_asm #(
      .TYPE_OFS(TYPE_OFS), .SRC_OFS(SRC_OFS), .SEQ_OFS(SEQ_OFS),
      .LAST_OFS(LAST_OFS), .CW(CW)
    ) u_asm (
      .clk(clk), .rst_n(rst_n), .sof(sof_a[d]), .valid(val_a[d]), .data(dat_a[d]),
      .done(done), .type_nxt(type_nxt), .src_nxt(src_nxt), .seq_nxt(seq_nxt)
    );

    ptp_ts_capture u_cap (
      .clk(clk), .rst_n(rst_n), .sof(sof_a[d]), .time_now(time_now),
      .done(done), .want_type(want), .type_nxt(type_nxt),
      .src_nxt(src_nxt), .seq_nxt(seq_nxt), .clr(clr_a[d]),
      .ts(ts_a[d]), .src_id(src_a[d]), .seq(seq_a[d]), .flag(flag_a[d])
    );
  end

  assign rx_ts = ts_a[0];   assign rx_src_id = src_a[0];
  assign rx_seq = seq_a[0]; assign rx_flag = flag_a[0];
  assign tx_ts = ts_a[1];   assign tx_src_id = src_a[1];
  assign tx_seq = seq_a[1]; assign tx_flag = flag_a[1];

endmodule

// File: rtl/ptp_ts_checker.sv
module ptp_ts_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        tx_valid,
  input logic        rx_flag_clr,
  input logic        tx_flag_clr,
  input logic [63:0] rx_ts,
  input logic [47:0] rx_src_id,
  input logic [15:0] rx_seq,
  input logic        rx_flag,
  input logic [63:0] tx_ts,
  input logic [47:0] tx_src_id,
  input logic [15:0] tx_seq,
  input logic        tx_flag
);

  AST_RX_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable({rx_ts, rx_src_id, rx_seq})) else $error("rx record moved without valid"); // R9
  AST_TX_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> $stable({tx_ts, tx_src_id, tx_seq})) else $error("tx record moved without valid"); // R9
  AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && !rx_flag_clr |=> rx_flag) else $error("rx flag dropped"); // R7
  AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flag && !tx_flag_clr |=> tx_flag) else $error("tx flag dropped"); // R7
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag_clr && !rx_valid |=> !rx_flag) else $error("rx clear ignored"); // R7
  AST_RX_RISE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !$rose(rx_flag)) else $error("rx flag rose without byte"); // R11
  AST_RX_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_seq) |-> rx_flag) else $error("rx capture without flag"); // R8
  AST_TX_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_seq) |-> tx_flag) else $error("tx capture without flag"); // R8

endmodule

bind ptp_event_timestamper ptp_ts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .rx_flag_clr(rx_flag_clr), .tx_flag_clr(tx_flag_clr),
  .rx_ts(rx_ts), .rx_src_id(rx_src_id), .rx_seq(rx_seq), .rx_flag(rx_flag),
  .tx_ts(tx_ts), .tx_src_id(tx_src_id), .tx_seq(tx_seq), .tx_flag(tx_flag)
);

// File: tb/sim_ptp_event_timestamper.sv
module sim_ptp_event_timestamper;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_master = 1;
  logic [63:0] tnow = 64'h1000;
  logic        rx_sof = 0, rx_valid = 0, rx_flag_clr = 0;
  logic        tx_sof = 0, tx_valid = 0, tx_flag_clr = 0;
  logic [7:0]  rx_data = 0, tx_data = 0;
  logic [63:0] rx_ts, tx_ts;
  logic [47:0] rx_src_id, tx_src_id;
  logic [15:0] rx_seq, tx_seq;
  logic        rx_flag, tx_flag;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tnow <= tnow + 64'd7;

  ptp_event_timestamper u0 (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .time_now(tnow),
    .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data), .rx_flag_clr(rx_flag_clr),
    .tx_sof(tx_sof), .tx_valid(tx_valid), .tx_data(tx_data), .tx_flag_clr(tx_flag_clr),
    .rx_ts(rx_ts), .rx_src_id(rx_src_id), .rx_seq(rx_seq), .rx_flag(rx_flag),
    .tx_ts(tx_ts), .tx_src_id(tx_src_id), .tx_seq(tx_seq), .tx_flag(tx_flag)
  );

  // expected records per direction (0 = rx, 1 = tx)
  logic [63:0] e_ts [2];
  logic [47:0] e_src[2];
  logic [15:0] e_seq[2];
  logic        e_flg[2];

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic put(input int d, input bit s, input bit v, input logic [7:0] b, input bit c = 0);
    if (d == 0) begin rx_sof = s; rx_valid = v; rx_data = b; rx_flag_clr = c; end
    else        begin tx_sof = s; tx_valid = v; tx_data = b; tx_flag_clr = c; end
    cyc();
    rx_sof = 0; rx_valid = 0; rx_flag_clr = 0; rx_data = 8'hEE;
    tx_sof = 0; tx_valid = 0; tx_flag_clr = 0; tx_data = 8'hEE;
  endtask

  function automatic logic [7:0] fbyte(input logic [3:0] ty, input logic [47:0] s,
                                       input logic [15:0] q, input int i);
    case (i)
      0: return {4'hA, ty};
      1: return 8'h02;
      2, 3, 4, 5, 6, 7: return s[8*(7-i) +: 8];
      8: return q[15:8];
      9: return q[7:0];
      default: return 8'h5A ^ 8'(i);
    endcase
  endfunction

  task automatic check1(input string r, input int d);
    logic [63:0] ats; logic [47:0] asr; logic [15:0] asq; logic af;
    ats = d ? tx_ts : rx_ts; asr = d ? tx_src_id : rx_src_id;
    asq = d ? tx_seq : rx_seq; af = d ? tx_flag : rx_flag;
    n_chk++;
    if (ats !== e_ts[d] || asr !== e_src[d] || asq !== e_seq[d] || af !== e_flg[d]) begin
      n_bad++;
      $display("FAIL %s dir%0d: got ts=%h src=%h seq=%h flag=%b exp ts=%h src=%h seq=%h flag=%b",
               r, d, ats, asr, asq, af, e_ts[d], e_src[d], e_seq[d], e_flg[d]);
    end
  endtask

  // sends a frame of nb bytes; gaps inserts idle cycles; sets expectations if it should match
  task automatic frame(input int d, input logic [3:0] ty, input logic [47:0] s,
                       input logic [15:0] q, input int nb, input bit gaps, input bit match);
    logic [63:0] t0;
    t0 = tnow;
    put(d, 1, 1, fbyte(ty, s, q, 0));
    for (int i = 1; i < nb; i++) begin
      if (gaps && (i % 3 == 0)) put(d, 0, 0, 8'hC3);
      put(d, 0, 1, fbyte(ty, s, q, i));
    end
    if (match) begin
      e_ts[d] = t0; e_src[d] = s; e_seq[d] = q; e_flg[d] = 1;
    end
  endtask

  task automatic t_reset();
    for (int d = 0; d < 2; d++) begin
      e_ts[d] = 0; e_src[d] = 0; e_seq[d] = 0; e_flg[d] = 0;
      check1("R1 reset", d);
    end
  endtask

  task automatic t_master();
    mode_master = 1;
    frame(0, 4'd0, 48'h111111111111, 16'h0101, 12, 0, 0);
    check1("R2 master rx ignores Sync", 0);
    frame(0, 4'd1, 48'hA1B2C3D4E5F6, 16'hBEEF, 12, 0, 1);
    check1("R2 R5 R6 master rx Delay_Req", 0);
    frame(1, 4'd1, 48'h222222222222, 16'h0202, 10, 0, 0);
    check1("R4 master tx ignores Delay_Req", 1);
    frame(1, 4'd0, 48'h0A0B0C0D0E0F, 16'h1234, 10, 0, 1);
    check1("R4 master tx Sync", 1);
    check1("R10 rx untouched by tx", 0);
  endtask

  task automatic t_slave();
    put(0, 0, 0, 8'h00, 1); e_flg[0] = 0;
    check1("R7 rx clear", 0);
    check1("R10 tx flag kept on rx clear", 1);
    put(1, 0, 0, 8'h00, 1); e_flg[1] = 0;
    check1("R7 tx clear", 1);
    mode_master = 0;
    frame(0, 4'd1, 48'h333333333333, 16'h0303, 12, 1, 0);
    check1("R3 slave rx ignores Delay_Req", 0);
    frame(0, 4'd0, 48'h998877665544, 16'h7F01, 12, 1, 1);
    check1("R3 R9 slave rx Sync with gaps", 0);
    frame(1, 4'd0, 48'h444444444444, 16'h0404, 10, 0, 0);
    check1("R4 slave tx ignores Sync", 1);
    frame(1, 4'd1, 48'hFEDCBA987654, 16'hC0DE, 10, 1, 1);
    check1("R4 slave tx Delay_Req", 1);
  endtask

  task automatic t_overwrite();
    repeat (5) cyc();
    check1("R7 flag sticky", 0);
    frame(0, 4'd0, 48'h0123456789AB, 16'hFFFF, 10, 0, 1);
    check1("R8 overwrite keeps flag", 0);
  endtask

  task automatic t_timing();
    logic [63:0] t0;
    logic [47:0] s = 48'hCAFE00112233;
    logic [15:0] q = 16'h8001;
    mode_master = 1;
    put(1, 0, 0, 8'h00, 1); e_flg[1] = 0;
    put(1, 0, 0, 8'h00);
    t0 = tnow;
    tx_sof = 1;
    put(1, 1, 0, 8'h77);  // sof alone, byte 0 follows
    for (int i = 0; i < 9; i++) put(1, 0, 1, fbyte(4'd0, s, q, i));
    check1("R11 no change before offset 9", 1);
    put(1, 0, 1, fbyte(4'd0, s, q, 9), 1);  // capture with clear same edge
    e_ts[1] = t0; e_src[1] = s; e_seq[1] = q; e_flg[1] = 1;
    check1("R11 R7 capture at offset 9, set beats clear", 1);
    for (int i = 10; i < 16; i++) put(1, 0, 1, fbyte(4'd0, 48'h0, 16'h0, i));
    for (int i = 0; i < 10; i++) put(1, 0, 1, fbyte(4'd0, 48'h5, 16'h5, i));
    check1("R9 trailing and sof-less bytes ignored", 1);
    frame(1, 4'd0, 48'h666666666666, 16'h0606, 7, 0, 0);
    check1("R9 short frame ignored", 1);
    frame(1, 4'd0, 48'h777777777777, 16'h0707, 10, 0, 1);
    check1("R5 next full frame after short one", 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_master();
    t_slave();
    t_overwrite();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule